// File: doc/BRIEF.md
# Microcoded Datapath Sequencer

This block is the control core of a processing element that can run in one of two modes: a distance mode and a force mode. In force mode a program counter steps through a small instruction store, one word per clock. There are no branches. Each word directly sets the operand selects and the add/subtract mode of two arithmetic units. It also carries strobes that gate accumulation into three force registers and one energy register, return the counter to word zero, and report that the unit is busy.

An outside mode controller drives `lj_mode`. It reads `busy` before it moves the unit back to distance mode. A program normally ends on a word that has the jump bit set and the busy bit clear, and that word is the safe point for a mode change. The instruction store is copied from the `PROG` parameter while reset is held. A separate clear input zeroes the accumulators.

Top module: `flex_seq`

## Requirements
- R1: Word bits: [1:0] unit 0 operand A, [3:2] unit 0 operand B, [4] unit 0 subtract, [6:5] unit 1 operand A, [8:7] unit 1 operand B, [9] unit 1 subtract, [11:10] force axis (0 x, 1 y, 2 z, 3 none), [12] force write, [13] energy write, [14] jump, [15] busy. Operand index 0..3 picks `din_a`..`din_d`. Each of `res0` and `res1` is A+B, or A-B when its subtract bit is 1, wrapped to W bits. Both appear combinationally in the same cycle as the word.
- R2: In force mode, when the jump bit is clear, `pc` advances by one on each clock.
- R3: A word with the jump bit set, executed in force mode, raises `jump` in that cycle, and `pc` is 0 on the next cycle.
- R4: While `lj_mode` is 0, `pc` becomes 0 at the next edge and stays there. `busy` and `jump` are 0, and no accumulator changes except through `acc_clr`.
- R5: In force mode, when the force write bit is set, the accumulator named by the axis field adds the sign-extended `res0` at the next edge. The other two force accumulators are unchanged. Axis 3 writes none of them.
- R6: In force mode, when the energy write bit is set, `energy` adds the sign-extended `res1` at the next edge.
- R7: `acc_clr` zeroes all four accumulators at the next edge and overrides any write in that cycle.
- R8: `busy` equals the busy bit of the current word whenever `lj_mode` is 1.
- R9: After reset, `pc` and all accumulators are 0. Word i of the store is `PROG[16*i+15:16*i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; loads the store |
| lj_mode | input | 1 | 1 = force mode, 0 = distance mode |
| acc_clr | input | 1 | Zero all accumulators |
| din_a | input | W | Operand 0 |
| din_b | input | W | Operand 1 |
| din_c | input | W | Operand 2 |
| din_d | input | W | Operand 3 |
| pc | output | $clog2(DEPTH) | Program counter |
| busy | output | 1 | Busy bit of current word, force mode only |
| jump | output | 1 | Jump bit of current word, force mode only |
| res0 | output | W | Unit 0 result |
| res1 | output | W | Unit 1 result |
| force_x | output | AW | X force accumulator |
| force_y | output | AW | Y force accumulator |
| force_z | output | AW | Z force accumulator |
| energy | output | AW | Energy accumulator |

## Verification
The operand results, `busy` and `jump` depend combinationally on the current word and the inputs, so they are due in the same cycle the inputs are applied. The counter and the four accumulators change one clock edge after the strobe, clear or mode change that causes the change. The bench applies inputs on the falling edge and compares every output a moment later. It holds a reference state that it updates once per cycle, after the comparison, so registered results are checked exactly one edge after their cause.

// File: rtl/flex_seq.sv
module flex_seq #(
  parameter int W = 16,
  parameter int AW = 24,
  parameter int DEPTH = 8,
  parameter logic [DEPTH*16-1:0] PROG = {16'h6000, {(DEPTH-1){16'h9010}}}
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lj_mode,
  input  logic                     acc_clr,
  input  logic [W-1:0]             din_a,
  input  logic [W-1:0]             din_b,
  input  logic [W-1:0]             din_c,
  input  logic [W-1:0]             din_d,
  output logic [$clog2(DEPTH)-1:0] pc,
  output logic                     busy,
  output logic                     jump,
  output logic [W-1:0]             res0,
  output logic [W-1:0]             res1,
  output logic [AW-1:0]            force_x,
  output logic [AW-1:0]            force_y,
  output logic [AW-1:0]            force_z,
  output logic [AW-1:0]            energy
);
  localparam int PW = $clog2(DEPTH);
  localparam int IW = 16;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [IW-1:0] rom [DEPTH];
  logic [IW-1:0] word;
  logic [W-1:0]  a0, b0, a1, b1;
  logic          fw_en, pe_en;
  logic [AW-1:0] ext0, ext1;

  function automatic logic [W-1:0] pick(input logic [1:0] idx,
      input logic [W-1:0] a, input logic [W-1:0] b,
      input logic [W-1:0] c, input logic [W-1:0] d);
    case (idx)
      2'd0: pick = a;
      2'd1: pick = b;
      2'd2: pick = c;
      default: pick = d;
    endcase
  endfunction

  always_ff @(posedge clk)
    if (!rst_n)
      for (int i = 0; i < DEPTH; i++) rom[i] <= PROG[i*IW +: IW];

  assign word = rom[pc];
  assign a0 = pick(word[1:0], din_a, din_b, din_c, din_d);
  assign b0 = pick(word[3:2], din_a, din_b, din_c, din_d);
  assign a1 = pick(word[6:5], din_a, din_b, din_c, din_d);
  assign b1 = pick(word[8:7], din_a, din_b, din_c, din_d);
  assign res0 = word[4] ? a0 - b0 : a0 + b0;
  assign res1 = word[9] ? a1 - b1 : a1 + b1;

  assign fw_en = lj_mode & word[12];
  assign pe_en = lj_mode & word[13];
  assign jump  = lj_mode & word[14];
  assign busy  = lj_mode & word[15];
  assign ext0  = {{(AW-W){res0[W-1]}}, res0};
  assign ext1  = {{(AW-W){res1[W-1]}}, res1};

  always_ff @(posedge clk) begin
    if (!rst_n || !lj_mode || jump) pc <= '0;
    else if (pc == LAST)            pc <= '0;
    else                            pc <= pc + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || acc_clr) begin
      force_x <= '0;
      force_y <= '0;
      force_z <= '0;
      energy  <= '0;
    end else begin
      if (fw_en && word[11:10] == 2'd0) force_x <= force_x + ext0;
      if (fw_en && word[11:10] == 2'd1) force_y <= force_y + ext0;
      if (fw_en && word[11:10] == 2'd2) force_z <= force_z + ext0;
      if (pe_en) energy <= energy + ext1;
    end
  end
endmodule

// File: rtl/flex_seq_chk.sv
module flex_seq_chk #(
  parameter int W = 16,
  parameter int AW = 24,
  parameter int DEPTH = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     lj_mode,
  input logic                     acc_clr,
  input logic [$clog2(DEPTH)-1:0] pc,
  input logic                     busy,
  input logic                     jump,
  input logic [AW-1:0]            force_x,
  input logic [AW-1:0]            force_y,
  input logic [AW-1:0]            force_z,
  input logic [AW-1:0]            energy
);
  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lj_mode && !jump && pc != ($clog2(DEPTH))'(DEPTH - 1) |=> pc == $past(pc) + 1'b1);
  // R3
  jump_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jump |=> pc == '0);
  // R4
  idle_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lj_mode |=> pc == '0);
  // R4
  idle_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lj_mode && !acc_clr |=> $stable(force_x) && $stable(force_y) && $stable(force_z) && $stable(energy));
  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clr |=> force_x == '0 && force_y == '0 && force_z == '0 && energy == '0);
  // R8
  busy_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy || jump |-> lj_mode);
endmodule

bind flex_seq flex_seq_chk #(.W(W), .AW(AW), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/test_flex_seq.sv
module test_flex_seq;
  localparam int PERIOD = 10;
  localparam int W = 16, AW = 24, DEPTH = 8;

  function automatic logic [15:0] mk(input int a0, b0, m0, a1, b1, m1, ax, fw, pe, jp, by);
    mk = 16'((a0) | (b0 << 2) | (m0 << 4) | (a1 << 5) | (b1 << 7) | (m1 << 9)
             | (ax << 10) | (fw << 12) | (pe << 13) | (jp << 14) | (by << 15));
  endfunction

  localparam logic [DEPTH*16-1:0] TPROG = {
    mk(0,2,1, 0,3,0, 0,0,1,1,0),
    mk(2,0,0, 1,3,1, 3,1,0,0,1),
    mk(1,1,0, 3,2,1, 1,1,0,0,1),
    mk(3,0,1, 0,1,0, 0,1,1,0,1),
    mk(0,3,0, 2,0,1, 3,0,0,0,1),
    mk(2,3,1, 1,3,0, 2,1,1,0,1),
    mk(1,2,1, 0,0,0, 1,1,0,0,1),
    mk(0,1,1, 2,3,0, 0,1,0,0,1)};

  logic clk = 0, rst_n = 0, lj_mode = 0, acc_clr = 0;
  logic [W-1:0] din_a = 0, din_b = 0, din_c = 0, din_d = 0;
  logic [2:0] pc;
  logic busy, jump;
  logic [W-1:0] res0, res1;
  logic [AW-1:0] force_x, force_y, force_z, energy;

  flex_seq #(.W(W), .AW(AW), .DEPTH(DEPTH), .PROG(TPROG)) i_flex_seq (.*);

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  int mpc;
  logic [AW-1:0] mf [3];
  logic [AW-1:0] me;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] opnd(input int i);
    case (i)
      0: opnd = din_a;
      1: opnd = din_b;
      2: opnd = din_c;
      default: opnd = din_d;
    endcase
  endfunction

  initial begin
    #(PERIOD*200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    mpc = 0; me = 0;
    for (int k = 0; k < 3; k++) mf[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R9 reset state
    chk("R9 pc", pc, 0);
    chk("R9 acc", force_x | force_y | force_z | energy, 0);
    for (int cyc = 0; cyc < 400; cyc++) begin
      logic [15:0] w;
      logic [W-1:0] e0, e1, x, y;
      bit lj;
      int ax;
      @(negedge clk);
      if (cyc < 6) lj = 0;
      else if (cyc < 61) lj = 1;
      else if (cyc < 71) lj = 0;
      else if (cyc < 201) lj = (cyc != 130);
      else lj = ($urandom_range(0, 9) < 8);
      lj_mode = lj;
      acc_clr = (cyc == 100 || cyc == 101 || cyc == 150 || (cyc > 200 && $urandom_range(0, 32) == 0));
      if (cyc >= 20 && cyc < 32) begin
        din_a = (cyc % 2) ? 16'h7FFF : 16'h8000;
        din_b = (cyc % 3) ? 16'h8000 : 16'hFFFF;
        din_c = 16'h7FFF; din_d = 16'h0001;
      end else begin
        din_a = 16'($urandom); din_b = 16'($urandom);
        din_c = 16'($urandom); din_d = 16'($urandom);
      end
      #1;
      w = TPROG[mpc*16 +: 16];
      x = opnd(int'(w[1:0])); y = opnd(int'(w[3:2]));
      e0 = w[4] ? x - y : x + y;
      x = opnd(int'(w[6:5])); y = opnd(int'(w[8:7]));
      e1 = w[9] ? x - y : x + y;
      chk("R1 res0", res0, e0);
      chk("R1 res1", res1, e1);
      chk("R2/R4 pc", pc, mpc);
      chk("R3 jump", jump, lj & w[14]);
      chk("R8 busy", busy, lj & w[15]);
      chk("R5 force_x", force_x, mf[0]);
      chk("R5 force_y", force_y, mf[1]);
      chk("R5 force_z", force_z, mf[2]);
      chk("R6 energy", energy, me);
      if (acc_clr) begin
        for (int k = 0; k < 3; k++) mf[k] = 0;
        me = 0;
      end else begin
        ax = int'(w[11:10]);
        if (lj && w[12] && ax < 3) mf[ax] = mf[ax] + AW'(signed'(e0));
        if (lj && w[13]) me = me + AW'(signed'(e1));
      end
      if (!lj || w[14]) mpc = 0;
      else mpc = (mpc + 1) % DEPTH;
    end
    @(negedge clk);
    // R7 clear with no further writes
    acc_clr = 1; lj_mode = 0;
    @(negedge clk);
    #1;
    chk("R7 clear", force_x | force_y | force_z | energy, 0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule